// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block derives a gated peripheral bus clock from the input clock by an integer ratio that software selects through one control word. The word holds a 7-bit divide field, a read-only flag that shows whether the last requested ratio is active, and an output-enable bit. Every write posts its divide field as a new request. The flag drops at once and rises again when the request has been taken up. Requests are only taken up where an output period ends, so that a pulse already under way is never cut short.

A ratio of one passes the input clock straight to the output through a gate that moves only while the input clock is low. All other ratios come from a counter with a registered output. The enable bit is also taken up at a period end, while the output is low, so stopping and restarting the clock never leaves a runt pulse. A second request that arrives while one is still waiting is parked. It is applied one period end later, and the most recent parked value wins.

Top module: `pbclk_divider`

## Requirements
- R1: Out of reset the control word reads 16'h0800: divide field 0, ready flag (bit 11) high, enable (bit 15) low. The output clock stays low.
- R2: With divide field D in bits [6:0], the output period is D+1 input cycles for every D from 0 to 127.
- R3: For ratios of two or more the high phase lasts floor(ratio/2) input cycles and the low phase takes the rest. A ratio of one gives the input clock itself.
- R4: A write makes the ready flag (bit 11) read low from the next cycle. The flag returns high on the cycle edge where the requested ratio becomes active, and that edge is a period end.
- R5: Bits [6:0] of the control word read back the active ratio field. Once ready is high again it equals the last value written.
- R6: A new ratio takes effect only at a period end. A write that lands on the last cycle of a period is taken up at the following period end, so one more full period of the old ratio is produced.
- R7: A write made while ready is low is held and applied at the period end after the pending request is taken up. Ready stays low until then, and the last such write wins.
- R8: Bit 15 enables the output. A change of the bit takes effect at a period end while the output is low. Every output pulse has the full high width, and with the bit clear the output stays low.
- R9: Bit 15 reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write; bit 11 is ignored |
| rd_data | output | 16 | Control word read back: divide field, ready flag, enable |
| pb_clk | output | 1 | Divided and gated peripheral bus clock |

## Verification
The two functions that can meet in one cycle are a software write and the end of an output period, where a request is taken up. The bench locks onto a rising output edge and places a write exactly on the last cycle of the next period. It then measures the following rising edges: two more periods of the old ratio must appear before the first period of the new one, and the ready flag must come back only when that period starts. A chained pair of writes also makes a parked request and a pending request change hands at one period end, and the bench judges that by the order of the field values read back.

// File: rtl/pbclk_div_pkg.sv
`timescale 1ns/1ps
package pbclk_div_pkg;

    localparam int DIV_W   = 7;
    localparam int CTRL_W  = 16;
    localparam int RDY_POS = 11;
    localparam int EN_POS  = 15;

    typedef logic [DIV_W-1:0] div_t;

    // One ratio request slot: a divide field plus a valid mark.
    typedef struct packed {
        logic valid;
        div_t div;
    } ratio_slot_t;

    // Number of input cycles the output stays high for a divide field.
    function automatic div_t high_cycles(input div_t d);
        logic [DIV_W:0] ratio;
        ratio = {1'b0, d} + 1'b1;
        return div_t'(ratio >> 1);
    endfunction

endpackage

// File: rtl/pbclk_div_req.sv
`timescale 1ns/1ps
module pbclk_div_req
    import pbclk_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              at_edge,
    output ratio_slot_t       pend,
    output logic              en_q,
    output logic              ready
);

    ratio_slot_t pend_q, park_q;
    ratio_slot_t pend_n, park_n;
    div_t        wr_div;

    assign wr_div = wr_data[DIV_W-1:0];

    always_comb begin
        pend_n = pend_q;
        park_n = park_q;
        // A period end takes the pending request; the parked one moves up.
        if (at_edge && pend_q.valid) begin
            pend_n       = park_q;
            park_n.valid = 1'b0;
        end
        // A write fills the first free slot after that move.
        if (wr_en) begin
            if (pend_n.valid) begin
                park_n = '{valid: 1'b1, div: wr_div};
            end else begin
                pend_n = '{valid: 1'b1, div: wr_div};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            park_q <= '0;
            en_q   <= 1'b0;
        end else begin
            pend_q <= pend_n;
            park_q <= park_n;
            if (wr_en) en_q <= wr_data[EN_POS];
        end
    end

    assign pend  = pend_q;
    assign ready = !pend_q.valid;

endmodule

// File: rtl/pbclk_div_phase.sv
`timescale 1ns/1ps
module pbclk_div_phase
    import pbclk_div_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  ratio_slot_t pend,
    input  logic        en_req,
    output logic        at_edge,
    output div_t        cur_div,
    output div_t        cnt,
    output logic        gate_on,
    output logic        out_q
);

    div_t next_div;
    div_t cnt_inc;

    assign at_edge  = (cnt == cur_div);
    assign next_div = pend.valid ? pend.div : cur_div;
    assign cnt_inc  = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cur_div <= '0;
            gate_on <= 1'b0;
            out_q   <= 1'b0;
        end else if (at_edge) begin
            cnt     <= '0;
            cur_div <= next_div;
            gate_on <= en_req;
            out_q   <= en_req && (high_cycles(next_div) != '0);
        end else begin
            cnt     <= cnt_inc;
            out_q   <= gate_on && (cnt_inc < high_cycles(cur_div));
        end
    end

endmodule

// File: rtl/pbclk_div_pass.sv
`timescale 1ns/1ps
module pbclk_div_pass
    import pbclk_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic gate_on,
    input  div_t cur_div,
    output logic pass_clk
);

    logic pass_en;

    // Updated on the falling edge only, so the AND below never chops a pulse.
    always_ff @(negedge clk) begin
        if (rst) pass_en <= 1'b0;
        else     pass_en <= gate_on && (cur_div == '0);
    end

    assign pass_clk = clk & pass_en;

endmodule

// File: rtl/pbclk_divider.sv
`timescale 1ns/1ps
module pbclk_divider
    import pbclk_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              pb_clk
);

    ratio_slot_t pend;
    logic        en_q;
    logic        ready;
    logic        at_edge;
    div_t        cur_div;
    div_t        cnt;
    logic        gate_on;
    logic        out_q;
    logic        pass_clk;

    pbclk_div_req u_req (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .at_edge (at_edge),
        .pend    (pend),
        .en_q    (en_q),
        .ready   (ready)
    );

    pbclk_div_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .en_req  (en_q),
        .at_edge (at_edge),
        .cur_div (cur_div),
        .cnt     (cnt),
        .gate_on (gate_on),
        .out_q   (out_q)
    );

    pbclk_div_pass u_pass (
        .clk      (clk),
        .rst      (rst),
        .gate_on  (gate_on),
        .cur_div  (cur_div),
        .pass_clk (pass_clk)
    );

    always_comb begin
        rd_data                = '0;
        rd_data[DIV_W-1:0]     = cur_div;
        rd_data[RDY_POS]       = ready;
        rd_data[EN_POS]        = en_q;
    end

    assign pb_clk = out_q | pass_clk;

endmodule

// File: rtl/pbclk_div_checker.sv
`timescale 1ns/1ps
module pbclk_div_checker
    import pbclk_div_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic ready,
    input logic at_edge,
    input div_t cur_div,
    input div_t cnt,
    input logic gate_on,
    input logic out_q
);

    // R2: the phase counter never passes the active divide field
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= cur_div);

    // R4: a write drops the ready flag on the next cycle
    a_r4_ready_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ready) |=> !ready);

    // R4: ready only comes back at a period end
    a_r4_ready_rise_at_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(at_edge));

    // R6: the active ratio only changes at a period end
    a_r6_load_at_edge: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_div) |-> $past(at_edge));

    // R8: the gate only moves while the divided output is low
    a_r8_gate_when_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(gate_on) |-> !$past(out_q));

    // R8: a closed gate keeps the divided output low
    a_r8_off_means_low: assert property (@(posedge clk) disable iff (rst)
        !gate_on |-> !out_q);

endmodule

bind pbclk_divider pbclk_div_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .ready   (ready),
    .at_edge (at_edge),
    .cur_div (cur_div),
    .cnt     (cnt),
    .gate_on (gate_on),
    .out_q   (out_q)
);

// File: tb/pbclk_divider_bench.sv
`timescale 1ns/1ps
module pbclk_divider_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        pb_clk;

    always #2.5 clk = ~clk;

    pbclk_divider u_pbclk_divider (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pb_clk  (pb_clk)
    );

    int  n_run  = 0;
    int  n_fail = 0;
    bit  finished = 0;
    int  exp_q[$];
    int  pushed = 0;
    int  served = 0;

    // Pulse width watcher for the gating checks
    bit      watch = 0;
    int      watch_hi_ps = 0;
    int      bad_pulses = 0;
    int      rises = 0;
    realtime t_rise = 0.0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int high_ps(input int r);
        return (r == 1) ? 2500 : (r / 2) * 5000;
    endfunction

    always @(posedge pb_clk) begin
        t_rise = $realtime;
        rises++;
    end

    always @(negedge pb_clk) begin
        if (watch && (int'(($realtime - t_rise) * 1000.0) != watch_hi_ps)) bad_pulses++;
    end

    // Monitor: pops each expected ratio and measures one full output period
    initial begin
        forever begin
            int r;
            realtime t0, t1, t2;
            wait (exp_q.size() != 0);
            r = exp_q.pop_front();
            @(posedge pb_clk) t0 = $realtime;
            @(negedge pb_clk) t1 = $realtime;
            @(posedge pb_clk) t2 = $realtime;
            check(int'((t1 - t0) * 1000.0) == high_ps(r), "R3 high phase",
                  int'((t1 - t0) * 1000.0), high_ps(r));
            check(int'((t2 - t0) * 1000.0) == r * 5000, "R2 period",
                  int'((t2 - t0) * 1000.0), r * 5000);
            served++;
        end
    end

    task automatic write_word(input bit en, input int div);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = '0;
        wr_data[15]  = en;
        wr_data[6:0] = div[6:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 600; i++) begin
            if (rd_data[11]) break;
            @(negedge clk);
        end
    endtask

    // Driver: writes a ratio, follows the handshake, then queues the expectation
    task automatic run_ratio(input int r);
        write_word(1'b1, r - 1);
        check(rd_data[11] == 1'b0, "R4 ready low after write", rd_data[11], 0);
        wait_ready();
        check(rd_data[11] == 1'b1, "R4 ready returns", rd_data[11], 1);
        check(rd_data[6:0] == 7'(r - 1), "R5 readback", rd_data[6:0], r - 1);
        exp_q.push_back(r);
        pushed++;
        wait (served == pushed);
    endtask

    task automatic gate_toggles(input int r);
        watch_hi_ps = high_ps(r);
        bad_pulses  = 0;
        watch = 1;
        for (int k = 0; k < 5; k++) begin
            write_word(1'b0, r - 1);
            repeat (k + 3) @(negedge clk);
            write_word(1'b1, r - 1);
            repeat (2 * k + 7) @(negedge clk);
        end
        repeat (2 * r + 4) @(negedge clk);
        watch = 0;
        check(bad_pulses == 0, "R8 full pulses across gating", bad_pulses, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_data == 16'h0800, "R1 reset word", rd_data, 16'h0800);
        check(pb_clk == 1'b0, "R1 output low", pb_clk, 0);

        // R2 R3: every ratio
        for (int r = 1; r <= 128; r++) run_ratio(r);

        // R8 gating at ratio 6 and in pass-through
        run_ratio(6);
        gate_toggles(6);
        run_ratio(1);
        gate_toggles(1);

        // R8 R9: stopped output
        run_ratio(5);
        write_word(1'b0, 4);
        wait_ready();
        repeat (8) @(negedge clk);
        begin
            int r0;
            r0 = rises;
            repeat (40) @(negedge clk);
            check(rises == r0, "R8 no edges when disabled", rises - r0, 0);
        end
        check(pb_clk == 1'b0, "R8 output low when disabled", pb_clk, 0);
        check(rd_data[15] == 1'b0, "R9 enable reads 0", rd_data[15], 0);
        run_ratio(5);
        check(rd_data[15] == 1'b1, "R9 enable reads 1", rd_data[15], 1);

        // R7: second write while ready is low
        run_ratio(6);
        begin
            bit saw_mid = 0;
            bit early   = 0;
            write_word(1'b1, 49);
            write_word(1'b1, 9);
            for (int i = 0; i < 400; i++) begin
                if (rd_data[6:0] == 7'd49) saw_mid = 1;
                if (rd_data[11]) break;
                @(negedge clk);
            end
            if (rd_data[11] && rd_data[6:0] != 7'd9) early = 1;
            check(saw_mid, "R7 first request applied first", saw_mid, 1);
            check(!early, "R7 ready held until parked write applied", early, 0);
            check(rd_data[6:0] == 7'd9, "R7 last write wins", rd_data[6:0], 9);
            exp_q.push_back(10);
            pushed++;
            wait (served == pushed);
        end

        // R6: write landing on the last cycle of a period
        run_ratio(4);
        begin
            realtime t0, t1, t2, t3;
            @(posedge pb_clk) t0 = $realtime;
            repeat (3) @(posedge clk);
            @(negedge clk);
            wr_en   = 1'b1;
            wr_data = 16'h8007;
            @(posedge pb_clk) t1 = $realtime;
            @(negedge clk);
            wr_en = 1'b0;
            @(posedge pb_clk) t2 = $realtime;
            @(posedge pb_clk) t3 = $realtime;
            check(int'((t1 - t0) * 1000.0) == 20000, "R6 period at write",
                  int'((t1 - t0) * 1000.0), 20000);
            check(int'((t2 - t1) * 1000.0) == 20000, "R6 old ratio kept one more period",
                  int'((t2 - t1) * 1000.0), 20000);
            check(int'((t3 - t2) * 1000.0) == 40000, "R6 new ratio after boundary",
                  int'((t3 - t2) * 1000.0), 40000);
            @(negedge clk);
            check(rd_data[11] == 1'b1 && rd_data[6:0] == 7'd7, "R5 readback after boundary write",
                  rd_data[6:0], 7);
        end

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(150000 * 5);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule